// File: doc/BRIEF.md
# Exhaustive Key Search Sequencer

This block finds an unknown cipher key by trying every value in turn. It works with an external decryption engine, which it drives through an enable/done handshake. For each candidate key it raises the engine enable and waits for the engine to report done. It then captures the 128-bit result and judges whether every byte is printable. If the result is not printable, it drops the enable, steps the key by one and tries again.

When a result passes the test, the search halts and a stopwatch run flag is released. The captured text goes to a serial text drawer, together with a draw request held until the drawer answers. The upper bits of the candidate key are brought out for a display, so progress stays visible during long searches.

The state machine has six states:
- `ST_IDLE` waits for start. Its transition *launch* clears the key and enters `ST_RUN`.
- `ST_RUN` holds the enable high. Its transition *capture*, taken on engine done, latches the text and enters `ST_JUDGE`.
- `ST_JUDGE` decides what happens next:
  - *accept* enters `ST_SHOW` when the text is readable.
  - *retry* steps the key and returns to `ST_RUN`.
  - *exhaust* enters `ST_FAIL` when the all-ones key has also failed.
- `ST_SHOW` asserts the draw request. Its transition *drawn*, taken on drawer done, enters `ST_DONE`.
- `ST_DONE` and `ST_FAIL` are terminal until reset.

Top module: `key_search_ctrl`

## Requirements
- R1: After reset the key is 0, and the engine enable, the draw request and the stopwatch run flag are all low. They stay that way until start is asserted.
- R2: A start pulse in idle begins the search at key 0. The engine enable and the run flag are high from the next cycle.
- R3: While the engine has not reported done, the enable stays high and the key does not change.
- R4: A result is readable only when each of its 16 bytes is 0x41..0x5A, 0x30..0x39 or 0x20. Any other byte value, including 0x40, 0x5B, 0x2F, 0x3A, 0x21, lower-case letters and 0x00, makes it unreadable.
- R5: An unreadable result makes the key step by exactly one. The enable is low for at least one cycle and then rises again for the new key. A key of 5 is therefore accepted on the sixth enable pulse.
- R6: A readable result stops the search. The run flag goes low, the enable stays low, and the key holds the accepted value.
- R7: The key display output equals the upper 16 bits of the current key (key[23:8]).
- R8: After acceptance, the text output carries the captured result with its first character in bits [127:120]. The draw request is held high until drawer done, then dropped for good. The block stays terminal until reset.
- R9: If the all-ones key also fails, the block enters a failure state. In that state the draw request is never raised, the run flag is low and the enable is low.
- R10: Start has no effect outside idle. It neither restarts the key during a search nor leaves a terminal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| start_i | input | 1 | Begin the search |
| eng_done_i | input | 1 | Decryption engine reports result valid |
| eng_text_i | input | 128 | Decryption engine result |
| draw_done_i | input | 1 | Text drawer has finished |
| key_o | output | 24 | Candidate key given to the engine |
| eng_en_o | output | 1 | Engine enable; a rising edge starts an attempt |
| draw_req_o | output | 1 | Request to the text drawer |
| text_o | output | 128 | Captured result for the drawer |
| timer_run_o | output | 1 | Stopwatch run flag |
| key_disp_o | output | 16 | Upper bits of the candidate key |

## Verification
The assertions assume that the engine's done flag falls within one cycle of the enable falling. They also assume that its result is steady while done is high, and that drawer done comes only after a request. The stub engine in the bench meets these assumptions: it clears done on the first edge that sees the enable low, and it derives its text purely from the key. The bench pulses drawer done only while the draw request is visible. A second instance with a 4-bit key reaches the wrap-around failure path within a short run.

// File: rtl/kbs_pkg.sv
package kbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_JUDGE,
        ST_SHOW,
        ST_DONE,
        ST_FAIL
    } ks_state_t;

    localparam logic [7:0] CH_SPACE = 8'h20;
    localparam logic [7:0] CH_DIG_LO = 8'h30;
    localparam logic [7:0] CH_DIG_HI = 8'h39;
    localparam logic [7:0] CH_UP_LO = 8'h41;
    localparam logic [7:0] CH_UP_HI = 8'h5A;

endpackage

// File: rtl/kbs_text_judge.sv
module kbs_text_judge #(
    parameter int BYTES = 16
) (
    input  logic [BYTES*8-1:0] text_i,
    output logic               ok_o
);
    import kbs_pkg::*;

    logic [BYTES-1:0] byte_ok;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        logic [7:0] ch;
        assign ch = text_i[b*8 +: 8];
        assign byte_ok[b] = (ch >= CH_UP_LO && ch <= CH_UP_HI) ||
                            (ch >= CH_DIG_LO && ch <= CH_DIG_HI) ||
                            (ch == CH_SPACE);
    end

    assign ok_o = &byte_ok;

endmodule

// File: rtl/kbs_key_counter.sv
module kbs_key_counter #(
    parameter int KEY_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [KEY_W-1:0] key_o,
    output logic             last_o
);
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            key_o <= '0;
        end else if (step_i) begin
            key_o <= key_o + 1'b1;
        end
    end

    assign last_o = &key_o;

    // R5: the key moves only by a single step
    a_r5_step_by_one: assert property (@(posedge clk) disable iff (rst)
        ($past(step_i) && !$past(clear_i)) |-> key_o == $past(key_o) + 1'b1);

endmodule

// File: rtl/key_search_ctrl.sv
module key_search_ctrl #(
    parameter int KEY_W = 24,
    parameter int TEXT_BYTES = 16,
    parameter int DISP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    eng_done_i,
    input  logic [TEXT_BYTES*8-1:0] eng_text_i,
    input  logic                    draw_done_i,
    output logic [KEY_W-1:0]        key_o,
    output logic                    eng_en_o,
    output logic                    draw_req_o,
    output logic [TEXT_BYTES*8-1:0] text_o,
    output logic                    timer_run_o,
    output logic [DISP_W-1:0]       key_disp_o
);
    import kbs_pkg::*;

    localparam int TEXT_W = TEXT_BYTES * 8;

    ks_state_t state, state_nx;
    logic [TEXT_W-1:0] text_q;
    logic text_ok, key_last, key_clear, key_step;

    kbs_text_judge #(.BYTES(TEXT_BYTES)) u_judge (
        .text_i(text_q),
        .ok_o  (text_ok)
    );

    kbs_key_counter #(.KEY_W(KEY_W)) u_key (
        .clk    (clk),
        .rst    (rst),
        .clear_i(key_clear),
        .step_i (key_step),
        .key_o  (key_o),
        .last_o (key_last)
    );

    // state register and result capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            text_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_RUN && eng_done_i) begin
                text_q <= eng_text_i;
            end
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_i) state_nx = ST_RUN;
            ST_RUN:   if (eng_done_i) state_nx = ST_JUDGE;
            ST_JUDGE: begin
                if (text_ok)       state_nx = ST_SHOW;
                else if (key_last) state_nx = ST_FAIL;
                else               state_nx = ST_RUN;
            end
            ST_SHOW:  if (draw_done_i) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_DONE;
            ST_FAIL:  state_nx = ST_FAIL;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        eng_en_o    = 1'b0;
        draw_req_o  = 1'b0;
        timer_run_o = 1'b0;
        key_clear   = 1'b0;
        key_step    = 1'b0;
        unique case (state)
            ST_IDLE:  key_clear = start_i;
            ST_RUN: begin
                eng_en_o    = 1'b1;
                timer_run_o = 1'b1;
            end
            ST_JUDGE: begin
                timer_run_o = !text_ok;
                key_step    = !text_ok && !key_last;
            end
            ST_SHOW:  draw_req_o = 1'b1;
            default:  ;
        endcase
    end

    assign text_o     = text_q;
    assign key_disp_o = key_o[KEY_W-1 -: DISP_W];

    // R2: the engine only runs while the stopwatch runs
    a_r2_en_in_search: assert property (@(posedge clk) disable iff (rst)
        eng_en_o |-> timer_run_o);

    // R3: key is frozen while waiting on the engine
    a_r3_hold_key: assert property (@(posedge clk) disable iff (rst)
        (eng_en_o && !eng_done_i) |=> $stable(key_o));

    // R6: a draw request only follows a readable capture
    a_r6_accept_ok: assert property (@(posedge clk) disable iff (rst)
        $rose(draw_req_o) |-> (text_ok && !timer_run_o && !eng_en_o));

    // R8: request is held until the drawer answers
    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        (draw_req_o && !draw_done_i) |=> draw_req_o);

    // R8: the done state is terminal
    a_r8_terminal: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_DONE && !draw_req_o));

    // R9: failure only after the all-ones key was judged
    a_r9_fail_at_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_FAIL) |-> ($past(key_last) && !draw_req_o && !timer_run_o));

endmodule

// File: tb/key_search_ctrl_test.sv
`timescale 1ns/1ps

module kbs_engine_stub #(
    parameter int KW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [KW-1:0] key,
    input  logic [7:0]    lat,
    input  logic [127:0]  probe,
    input  logic [127:0]  good,
    input  logic [KW-1:0] good_key,
    input  logic          never,
    output logic          done,
    output logic [127:0]  text
);
    logic [7:0] cnt;
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (cnt >= lat) begin
            done <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
    always_comb begin
        if (never)                text = {16{8'h7E}};
        else if (key == '0)       text = probe;
        else if (key == good_key) text = good;
        else                      text = {16{8'h7E}};
    end
endmodule

module key_search_ctrl_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    logic rst, start, ddone;
    logic [7:0] lat;
    logic [127:0] probe, good;
    logic [23:0] gkey;
    logic edone;
    logic [127:0] etext;
    logic [23:0] key;
    logic en, dreq, run;
    logic [127:0] txt;
    logic [15:0] kdisp;

    // small instance for the wrap-around path
    logic s_edone, s_en, s_dreq, s_run;
    logic [127:0] s_etext, s_txt;
    logic [3:0] s_key;
    logic [1:0] s_kdisp;

    kbs_engine_stub #(.KW(24)) u_stub (
        .clk(clk), .rst(rst), .en(en), .key(key), .lat(lat), .probe(probe),
        .good(good), .good_key(gkey), .never(1'b0), .done(edone), .text(etext));

    key_search_ctrl uut (
        .clk(clk), .rst(rst), .start_i(start), .eng_done_i(edone),
        .eng_text_i(etext), .draw_done_i(ddone), .key_o(key), .eng_en_o(en),
        .draw_req_o(dreq), .text_o(txt), .timer_run_o(run), .key_disp_o(kdisp));

    kbs_engine_stub #(.KW(4)) u_stub_s (
        .clk(clk), .rst(rst), .en(s_en), .key(s_key), .lat(8'd1), .probe(good),
        .good(good), .good_key(4'd3), .never(1'b1), .done(s_edone), .text(s_etext));

    key_search_ctrl #(.KEY_W(4), .DISP_W(2)) uut_small (
        .clk(clk), .rst(rst), .start_i(start), .eng_done_i(s_edone),
        .eng_text_i(s_etext), .draw_done_i(1'b0), .key_o(s_key), .eng_en_o(s_en),
        .draw_req_o(s_dreq), .text_o(s_txt), .timer_run_o(s_run), .key_disp_o(s_kdisp));

    // enable pulse counters
    int tries = 0, s_tries = 0;
    logic en_d = 1'b0, s_en_d = 1'b0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        en_d <= en;
        s_en_d <= s_en;
        if (rst) begin
            tries <= 0;
            s_tries <= 0;
        end else begin
            if (en && !en_d) tries <= tries + 1;
            if (s_en && !s_en_d) s_tries <= s_tries + 1;
        end
    end

    task automatic ck(input bit cond, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 1'b0; ddone = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_req(input int lim, output bit hit);
        hit = 1'b0;
        for (int i = 0; i < lim; i++) begin
            if (dreq) begin hit = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    localparam int NV = 8;
    localparam logic [127:0] VEC_TEXT [NV] = '{
        128'("HELLO WORLD 2024"),
        128'("ZZZZ 0000 9999 A"),
        128'("HELLO@WORLD 2024"),
        128'("HELLO[WORLD 2024"),
        128'("HELLO/WORLD 2024"),
        128'("HELLO:WORLD 2024"),
        128'("hello world 2024"),
        {120'("HELLO WORLD 202"), 8'h00}
    };
    localparam bit VEC_OK [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

    initial begin
        bit hit;
        lat = 8'd2;
        good = 128'("SECRET KEY 00001");
        probe = {16{8'h7E}};
        gkey = 24'd1;
        do_reset();

        // R1: idle after reset
        ck(key == 0 && !en && !dreq && !run, "R1 reset state", {en, dreq, run}, 0);
        repeat (5) @(negedge clk);
        ck(!en && !run && tries == 0, "R1 no start no activity", tries, 0);

        // table walk: R4 readability rule
        for (int v = 0; v < NV; v++) begin
            probe = VEC_TEXT[v];
            gkey = 24'd1;
            do_reset();
            pulse_start();
            ck(en && run && key == 0, "R2 first attempt at key 0", key, 0);
            wait_req(200, hit);
            ck(hit, "R4 search ends", hit, 1);
            if (VEC_OK[v]) begin
                ck(key == 0 && txt == VEC_TEXT[v], "R4 readable accepted", txt, VEC_TEXT[v]);
                ck(tries == 1, "R4 one attempt", tries, 1);
            end else begin
                ck(key == 1 && txt == good, "R4 unreadable rejected", txt, good);
                ck(tries == 2, "R5 second attempt", tries, 2);
            end
            ck(!run && !en, "R6 stopped", {run, en}, 0);
            ddone = 1'b1; @(negedge clk); ddone = 1'b0;
        end

        // R5: key 5 on the sixth attempt, enable gap
        probe = {16{8'h7E}};
        gkey = 24'd5;
        do_reset();
        pulse_start();
        begin
            bit gap_seen = 1'b0;
            for (int i = 0; i < 300 && !dreq; i++) begin
                if (!en && run) gap_seen = 1'b1;
                @(negedge clk);
            end
            ck(gap_seen, "R5 enable drops between attempts", gap_seen, 1);
        end
        ck(dreq && key == 24'd5, "R5 key 5 found", key, 5);
        ck(tries == 6, "R5 sixth attempt", tries, 6);
        // R8: request held, text first char in top byte
        ck(txt[127:120] == "S", "R8 first char position", txt[127:120], "S");
        repeat (3) @(negedge clk);
        ck(dreq, "R8 request held", dreq, 1);
        ddone = 1'b1; @(negedge clk); ddone = 1'b0;
        @(negedge clk);
        ck(!dreq && !en && !run, "R8 request dropped", dreq, 0);
        pulse_start();
        repeat (10) @(negedge clk);
        ck(!dreq && !en && key == 5 && tries == 6, "R10 terminal ignores start", tries, 6);

        // R3 and R10: slow engine, start during search
        lat = 8'd20;
        gkey = 24'd2;
        do_reset();
        pulse_start();
        repeat (6) @(negedge clk);
        ck(en && key == 0, "R3 waits for engine done", key, 0);
        @(negedge clk);
        repeat (25) @(negedge clk);
        ck(key == 1, "R3 key stepped after done", key, 1);
        pulse_start();
        ck(key == 1, "R10 start ignored during search", key, 1);
        wait_req(400, hit);
        ck(hit && key == 2 && tries == 3, "R10 search completes", key, 2);
        ddone = 1'b1; @(negedge clk); ddone = 1'b0;

        // R7: display carries key[23:8]
        lat = 8'd1;
        gkey = 24'h000305;
        do_reset();
        pulse_start();
        wait_req(20000, hit);
        ck(hit && key == 24'h000305, "R6 long search found", key, 24'h000305);
        ck(kdisp == 16'h0003, "R7 key display", kdisp, 16'h0003);
        repeat (4) @(negedge clk);
        ck(key == 24'h000305 && !run, "R6 key held after accept", key, 24'h000305);

        // R9: wrap-around failure on the 4-bit instance (ran alongside)
        begin
            bit s_hit = 1'b0;
            bit s_req_seen = 1'b0;
            do_reset();
            pulse_start();
            for (int i = 0; i < 500; i++) begin
                if (s_dreq) s_req_seen = 1'b1;
                if (!s_run && s_tries > 0) begin s_hit = 1'b1; break; end
                @(negedge clk);
            end
            repeat (10) @(negedge clk);
            if (s_dreq) s_req_seen = 1'b1;
            ck(s_hit && s_key == 4'hF, "R9 wrap failure key", s_key, 4'hF);
            ck(s_tries == 16 && !s_en && !s_run, "R9 all keys tried", s_tries, 16);
            ck(!s_req_seen, "R9 no draw request", s_req_seen, 0);
            ck(s_kdisp == 2'b11, "R7 display on small instance", s_kdisp, 2'b11);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule